// File: doc/BRIEF.md
# Magic-Word Watchdog Timer

This block is a watchdog timer on a simple 32-bit register bus. The bus has an address, a write enable, write data and read data, and it takes word accesses only. The watchdog holds a down-counter that is loaded from a reload register. The counter drops by one in every clock cycle in which the tick-enable input is high. Software keeps the system alive by writing one fixed 16-bit key to a restart register at regular intervals. If the counter reaches zero first, the block latches an expiry flag. It can then hold an interrupt line high and send a one-cycle system-reset request.

The restart write takes effect only when the key matches exactly and the timer is enabled. Any other write to that register changes nothing. The expiry flag is cleared through a separate write-one-to-clear register. A write to the control register that leaves the enable bit set does not restart a count that is already running. Only a change from disabled to enabled loads the counter.

Top module: `watchdog_core`

## Requirements
- R1: After reset, control and status read 0, the interrupt-length register reads 0, the reload register reads 0x03EF1480, a counter read returns the reload value, and both outputs are low.
- R2: The word offsets are: counter 0x00 (read only), reload 0x04, restart 0x08, control 0x0C, status 0x10, status-clear 0x14, interrupt-length 0x18 and revision 0x1C. The revision register reads 0x00010601. Control bit 0 is enable, bit 1 enables the reset request and bit 2 enables the interrupt. Bits 3 and 4 are stored and read back with no effect. Control bits above 4 read 0. The interrupt-length register stores and returns a full word.
- R3: A control write that sets enable while the timer is disabled loads the counter from the reload value at that clock edge. From then on the counter drops by one at each edge where tick-enable is high, and it does not change at edges where tick-enable is low.
- R4: A control write with enable set while the timer is already enabled leaves the counter unchanged.
- R5: A write to the restart register reloads the counter only when the timer is enabled and the data equals 0x00005AB9. Any other data value leaves the counter unchanged.
- R6: While the timer is enabled, a counter read returns the smaller of the remaining count and the reload value. While it is disabled, a counter read returns the reload value. Clearing the enable bit stops the count.
- R7: A load from a reload value of 0 places 1 in the counter, so the timer expires after one tick.
- R8: When a tick takes the counter from 1 to 0, the status register reads 0x00000002 after that edge. The counter then stays at 0, and no further expiry happens until the counter is reloaded.
- R9: The interrupt output is high exactly while status bit 1 is set and control bit 2 is set.
- R10: At an expiry edge the reset-request output goes high for exactly one cycle, but only if control bit 1 is set.
- R11: A write to the status-clear register clears each status bit whose write-data bit is 1. Reads of the restart and status-clear offsets return 0.
- R12: Reads of undefined offsets (0x20 and above) or of addresses with the low two bits not 0 return 0. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count-enable strobe; the counter drops once per high cycle |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_we_i | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Level interrupt on expiry |
| sys_rst_req_o | output | 1 | One-cycle system-reset request on expiry |

## Verification
The assertions check on every cycle that the reset request never lasts more than one cycle and only appears together with the expiry flag. They also check that the interrupt never shows without the flag, that the counter read never exceeds the reload value, that the counter holds when tick-enable is low and holds at zero after expiry, and that a load never places zero in the counter. Only the bench scenarios can show the cycle at which expiry lands for each reload value. The same goes for the rejection of near-miss keys, the non-restarting control rewrite, the write-one-to-clear masking, and the silence of undefined and misaligned accesses.

// File: rtl/watchdog_pkg.sv
package watchdog_pkg;
   // word indices (byte offset / 4)
   localparam int unsigned IDX_COUNT    = 0;
   localparam int unsigned IDX_RELOAD   = 1;
   localparam int unsigned IDX_KICK     = 2;
   localparam int unsigned IDX_CTRL     = 3;
   localparam int unsigned IDX_STATUS   = 4;
   localparam int unsigned IDX_STAT_CLR = 5;
   localparam int unsigned IDX_PULSELEN = 6;
   localparam int unsigned IDX_VERSION  = 7;

   // control field positions
   localparam int unsigned CTL_EN      = 0;
   localparam int unsigned CTL_RST_EN  = 1;
   localparam int unsigned CTL_IRQ_EN  = 2;
   localparam int unsigned CTL_EXT_EN  = 3;
   localparam int unsigned CTL_CLK_SEL = 4;
   localparam int unsigned CTL_BITS    = 5;

   // status field position
   localparam int unsigned STAT_EXPIRED = 1;
endpackage

// File: rtl/watchdog_count.sv
module watchdog_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] load_val;
   logic             can_dec;

   // a zero reload still gives one tick
   assign load_val = (reload_i == ZERO) ? ONE : reload_i;
   assign can_dec  = run_i && !load_i && tick_i && (cnt_q != ZERO);
   assign expire_o = can_dec && (cnt_q == ONE);

   always_comb begin
      cnt_d = cnt_q;
      if (load_i)       cnt_d = load_val;
      else if (can_dec) cnt_d = cnt_q - ONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= ZERO;
      else         cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   // R3: no tick, no movement
   a_r3_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !load_i && !tick_i) |=> $stable(cnt_q));
   // R8: expired counter stays at zero
   a_r8_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !load_i && cnt_q == ZERO) |=> (cnt_q == ZERO));
   // R7: a load never yields zero
   a_r7_load_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (cnt_q != ZERO));
endmodule

// File: rtl/watchdog_expiry.sv
module watchdog_expiry (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic expire_i,
   input  logic clr_i,
   input  logic rst_en_i,
   input  logic irq_en_i,
   output logic flag_o,
   output logic irq_o,
   output logic rst_req_o
);
   logic flag_q;
   logic req_q;

   // expiry wins over a same-cycle clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         if (expire_i)   flag_q <= 1'b1;
         else if (clr_i) flag_q <= 1'b0;
         req_q <= expire_i && rst_en_i;
      end
   end

   assign flag_o    = flag_q;
   assign irq_o     = flag_q && irq_en_i;
   assign rst_req_o = req_q;

   // R8: expiry always latches the flag
   a_r8_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_i |=> flag_q);
   // R10: request never longer than one cycle
   a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_q |=> !req_q);
endmodule

// File: rtl/watchdog_regs.sv
module watchdog_regs
   import watchdog_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter logic [DATA_W-1:0] RELOAD_INIT = 32'h03EF_1480,
   parameter logic [DATA_W-1:0] KEY         = 32'h0000_5AB9,
   parameter logic [DATA_W-1:0] VERSION     = 32'h0001_0601
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] cnt_i,
   input  logic              flag_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] reload_o,
   output logic              run_o,
   output logic              rst_en_o,
   output logic              irq_en_o,
   output logic              load_o,
   output logic              clr_o
);
   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam logic [IDX_W-1:0] I_COUNT    = IDX_W'(IDX_COUNT);
   localparam logic [IDX_W-1:0] I_RELOAD   = IDX_W'(IDX_RELOAD);
   localparam logic [IDX_W-1:0] I_KICK     = IDX_W'(IDX_KICK);
   localparam logic [IDX_W-1:0] I_CTRL     = IDX_W'(IDX_CTRL);
   localparam logic [IDX_W-1:0] I_STATUS   = IDX_W'(IDX_STATUS);
   localparam logic [IDX_W-1:0] I_STAT_CLR = IDX_W'(IDX_STAT_CLR);
   localparam logic [IDX_W-1:0] I_PULSELEN = IDX_W'(IDX_PULSELEN);
   localparam logic [IDX_W-1:0] I_VERSION  = IDX_W'(IDX_VERSION);

   logic [IDX_W-1:0]    idx;
   logic                aligned;
   logic                wr_reload, wr_kick, wr_ctrl, wr_clr, wr_plen;
   logic [DATA_W-1:0]   reload_q;
   logic [DATA_W-1:0]   plen_q;
   logic [CTL_BITS-1:0] ctrl_q;
   logic [DATA_W-1:0]   cnt_view;
   logic [DATA_W-1:0]   ctrl_word;
   logic [DATA_W-1:0]   stat_word;

   assign idx     = addr_i[ADDR_W-1:2];
   assign aligned = (addr_i[1:0] == 2'b00);

   assign wr_reload = we_i && aligned && (idx == I_RELOAD);
   assign wr_kick   = we_i && aligned && (idx == I_KICK);
   assign wr_ctrl   = we_i && aligned && (idx == I_CTRL);
   assign wr_clr    = we_i && aligned && (idx == I_STAT_CLR);
   assign wr_plen   = we_i && aligned && (idx == I_PULSELEN);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reload_q <= RELOAD_INIT;
         plen_q   <= '0;
      end else begin
         if (wr_reload) reload_q <= wdata_i;
         if (wr_plen)   plen_q   <= wdata_i;
      end
   end

   // one flop per control field
   for (genvar b = 0; b < CTL_BITS; b++) begin : g_ctl
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      ctrl_q[b] <= 1'b0;
         else if (wr_ctrl) ctrl_q[b] <= wdata_i[b];
      end
   end

   // load on enable edge or on a valid key while running
   assign load_o = (wr_ctrl && wdata_i[CTL_EN] && !ctrl_q[CTL_EN]) ||
                   (wr_kick && ctrl_q[CTL_EN] && (wdata_i == KEY));
   assign clr_o    = wr_clr && wdata_i[STAT_EXPIRED];
   assign run_o    = ctrl_q[CTL_EN];
   assign rst_en_o = ctrl_q[CTL_RST_EN];
   assign irq_en_o = ctrl_q[CTL_IRQ_EN];
   assign reload_o = reload_q;

   assign cnt_view  = !ctrl_q[CTL_EN] ? reload_q :
                      ((cnt_i < reload_q) ? cnt_i : reload_q);
   assign ctrl_word = {{(DATA_W-CTL_BITS){1'b0}}, ctrl_q};
   assign stat_word = DATA_W'(flag_i) << STAT_EXPIRED;

   always_comb begin
      rdata_o = '0;
      if (aligned) begin
         case (idx)
            I_COUNT:    rdata_o = cnt_view;
            I_RELOAD:   rdata_o = reload_q;
            I_CTRL:     rdata_o = ctrl_word;
            I_STATUS:   rdata_o = stat_word;
            I_PULSELEN: rdata_o = plen_q;
            I_VERSION:  rdata_o = VERSION;
            default:    rdata_o = '0;
         endcase
      end
   end

   // R6: counter view bounded by reload
   a_r6_view_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_view <= reload_q);
endmodule

// File: rtl/watchdog_core.sv
module watchdog_core #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 6,
   parameter logic [DATA_W-1:0] RELOAD_INIT = 32'h03EF_1480,
   parameter logic [DATA_W-1:0] KEY         = 32'h0000_5AB9,
   parameter logic [DATA_W-1:0] VERSION     = 32'h0001_0601
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_we_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o,
   output logic              sys_rst_req_o
);
   if (DATA_W < 16) begin : g_bad_width
      $error("watchdog_core: DATA_W must hold the 16-bit key");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("watchdog_core: ADDR_W must cover eight word registers");
   end

   logic [DATA_W-1:0] reload;
   logic [DATA_W-1:0] cnt;
   logic run, rst_en, irq_en, load, clr, expire, flag;

   watchdog_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RELOAD_INIT(RELOAD_INIT),
      .KEY(KEY), .VERSION(VERSION)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(bus_addr_i), .we_i(bus_we_i),
      .wdata_i(bus_wdata_i), .cnt_i(cnt), .flag_i(flag), .rdata_o(bus_rdata_o),
      .reload_o(reload), .run_o(run), .rst_en_o(rst_en), .irq_en_o(irq_en),
      .load_o(load), .clr_o(clr)
   );

   watchdog_count #(.CNT_W(DATA_W)) u_count (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .load_i(load),
      .reload_i(reload), .tick_i(tick_i), .cnt_o(cnt), .expire_o(expire)
   );

   watchdog_expiry u_expiry (
      .clk_i(clk_i), .rst_ni(rst_ni), .expire_i(expire), .clr_i(clr),
      .rst_en_i(rst_en), .irq_en_i(irq_en), .flag_o(flag), .irq_o(irq_o),
      .rst_req_o(sys_rst_req_o)
   );

   // R10: a request comes only with a fresh expiry flag
   a_r10_req_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sys_rst_req_o |-> flag);
   // R9: interrupt never without the flag
   a_r9_irq_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> flag);
endmodule

// File: tb/watchdog_core_tb_top.sv
module watchdog_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [5:0]  addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, rreq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   watchdog_core dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bus_addr_i(addr),
      .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_o(irq), .sys_rst_req_o(rreq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      addr = a; we = 1'b0;
      #1 d = rdata;
   endtask

   task automatic rdchk(input string req, input logic [5:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic do_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R1 reset state
      rdchk("R1 ctrl", 6'h0C, 32'h0);
      rdchk("R1 status", 6'h10, 32'h0);
      rdchk("R1 reload", 6'h04, 32'h03EF1480);
      rdchk("R1 count", 6'h00, 32'h03EF1480);
      rdchk("R1 intlen", 6'h18, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 rreq", {31'b0, rreq}, 32'h0);
      // R2 register map
      rdchk("R2 version", 6'h1C, 32'h00010601);
      wr(6'h18, 32'hA5A5_1234);
      rdchk("R2 intlen", 6'h18, 32'hA5A5_1234);
      wr(6'h0C, 32'hFFFF_FFF8);
      rdchk("R2 ctrl mask", 6'h0C, 32'h18);
      wr(6'h0C, 32'h0);
      // R11 write-only offsets read 0
      rdchk("R11 kick read", 6'h08, 32'h0);
      rdchk("R11 clr read", 6'h14, 32'h0);

      // R3 R8 R9 R10 sweep over reload values and enable combinations
      for (int L = 1; L <= 8; L++) begin
         logic ie, re;
         ie = L[0];
         re = L[1];
         wr(6'h0C, 32'h0);
         wr(6'h14, 32'hFFFF_FFFF);
         wr(6'h04, L);
         wr(6'h0C, {29'b0, ie, re, 1'b1});
         rdchk("R3 load", 6'h00, L);
         idle();
         rdchk("R3 tick low hold", 6'h00, L);
         for (int k = 1; k <= L; k++) begin
            do_tick();
            if (k < L) begin
               check("R10 no early req", {31'b0, rreq}, 32'h0);
               rdchk("R3 count", 6'h00, L - k);
               rdchk("R8 no early status", 6'h10, 32'h0);
            end else begin
               check("R10 req at expiry", {31'b0, rreq}, {31'b0, re});
               check("R9 irq level", {31'b0, irq}, {31'b0, ie});
               rdchk("R8 status", 6'h10, 32'h2);
               rdchk("R8 zero", 6'h00, 32'h0);
            end
         end
         idle();
         check("R10 one cycle", {31'b0, rreq}, 32'h0);
         do_tick();
         check("R8 no re-expiry", {31'b0, rreq}, 32'h0);
         rdchk("R8 hold zero", 6'h00, 32'h0);
         check("R9 irq held", {31'b0, irq}, {31'b0, ie});
      end

      // R4 R5 R6
      wr(6'h0C, 32'h0);
      wr(6'h14, 32'h2);
      wr(6'h04, 32'd10);
      wr(6'h0C, 32'h1);
      repeat (3) do_tick();
      rdchk("R3 after 3", 6'h00, 32'd7);
      wr(6'h0C, 32'h1);
      rdchk("R4 no restart", 6'h00, 32'd7);
      wr(6'h08, 32'h0000_5AB8);
      rdchk("R5 wrong key", 6'h00, 32'd7);
      wr(6'h08, 32'h0001_5AB9);
      rdchk("R5 upper bits", 6'h00, 32'd7);
      wr(6'h08, 32'h0000_5AB9);
      rdchk("R5 restart", 6'h00, 32'd10);
      wr(6'h04, 32'd4);
      rdchk("R6 clamp", 6'h00, 32'd4);
      do_tick();
      rdchk("R6 clamp after tick", 6'h00, 32'd4);
      wr(6'h08, 32'h0000_5AB9);
      do_tick();
      rdchk("R5 restart to new reload", 6'h00, 32'd3);
      wr(6'h0C, 32'h0);
      rdchk("R6 disabled view", 6'h00, 32'd4);
      do_tick();
      wr(6'h04, 32'd9);
      rdchk("R6 disabled follows reload", 6'h00, 32'd9);

      // R7 zero reload
      wr(6'h04, 32'd0);
      wr(6'h0C, 32'h7);
      rdchk("R7 view zero", 6'h00, 32'd0);
      rdchk("R7 no status yet", 6'h10, 32'h0);
      do_tick();
      check("R7 expiry after one tick", {31'b0, rreq}, 32'h1);
      rdchk("R7 status", 6'h10, 32'h2);

      // R11 write-one-to-clear
      wr(6'h14, 32'hFFFF_FFFD);
      rdchk("R11 masked clear", 6'h10, 32'h2);
      check("R11 irq kept", {31'b0, irq}, 32'h1);
      wr(6'h14, 32'h2);
      rdchk("R11 cleared", 6'h10, 32'h0);
      check("R9 irq drops", {31'b0, irq}, 32'h0);
      repeat (3) do_tick();
      rdchk("R8 stays clear", 6'h10, 32'h0);

      // R12 undefined and misaligned
      wr(6'h04, 32'd21);
      wr(6'h20, 32'hFFFF_FFFF);
      wr(6'h3C, 32'hFFFF_FFFF);
      wr(6'h0D, 32'h0);
      wr(6'h05, 32'h0);
      rdchk("R12 ctrl intact", 6'h0C, 32'h7);
      rdchk("R12 reload intact", 6'h04, 32'd21);
      rdchk("R12 undefined read", 6'h24, 32'h0);
      rdchk("R12 misaligned read", 6'h1D, 32'h0);
      check("R12 no irq", {31'b0, irq}, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule